// File: doc/BRIEF.md
# Programmable Timer Base with Deferred Divider Update

This block is a 16-bit up-counting timer base. A prescaler divides the incoming clock by a programmable ratio and produces count ticks. On each tick the counter advances by one. When the counter has reached the programmed period, the next tick returns it to zero and raises a single-cycle overflow pulse.

Software may write the counter, the period and the divider at any time. Counter and period writes act at once. A divider write is held in a pending register and only reaches the prescaler at the next overflow, so a ratio change never splits a period. While the period is zero the timer is frozen.

A single channel output is driven from an enable bit and a polarity bit.

Top module: `tmr_base`

## Requirements
- R1: After reset the counter reads 0, the overflow pulse is low, and the period, divider and pending divider registers hold 0. The timer therefore does not count until a nonzero period is written.
- R2: With an active divider value D and a nonzero period, the counter advances by one once every D+1 clock cycles.
- R3: When the counter equals the period P, the next tick sets it to 0. The overflow output is high for exactly the one cycle in which the counter first shows that 0. With P nonzero, successive overflow pulses are (P+1)*(D+1) cycles apart.
- R4: A divider write only updates a pending value. The prescaler keeps the old ratio until the next overflow, and at that overflow it loads the pending value and restarts its count from 0.
- R5: While the period register is 0, the counter and prescaler hold their values and no overflow is produced.
- R6: A counter write loads the written value, which is visible on the counter output in the next cycle. It takes priority over a tick in the same cycle, and it also works while the timer is halted.
- R7: The channel output is 0 when the enable is 0. When the enable is 1, the output is 1 with polarity 0 and 0 with polarity 1 (polarity 1 means active low).
- R8: A period write takes effect immediately, with no buffering. The counter wraps on the new value from the next tick on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write data |
| div_we | input | 1 | Divider write strobe (goes to the pending register) |
| div_wdata | input | 16 | Divider write data |
| per_we | input | 1 | Period write strobe |
| per_wdata | input | 16 | Period write data |
| out_en | input | 1 | Channel output enable |
| out_pol | input | 1 | Channel polarity, 1 = active low |
| cnt_val | output | 16 | Current counter value |
| ovf | output | 1 | One-cycle overflow pulse |
| ch_out | output | 1 | Channel output level |

## Verification
The bench sweeps divider values 0 to 3 against periods 1 to 4. In each case it predicts the counter value cycle by cycle from the divider and period, so an off-by-one in the prescaler compare or in the wrap point shows up as a wrong count or a wrong overflow spacing.

Buffering is checked by writing a new divider just after an overflow. A design that applied the divider at once would advance the counter too early.

Further checks cover:
- freezing the counter by writing a period of 0, where a design that kept ticking would drift;
- a counter write made in the same cycle as a tick, where a design that let the increment win would show one too many;
- all four enable and polarity combinations of the channel output.

// File: rtl/tmr_base.sv
module tmr_base #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         div_we,
  input  logic [W-1:0] div_wdata,
  input  logic         per_we,
  input  logic [W-1:0] per_wdata,
  input  logic         out_en,
  input  logic         out_pol,
  output logic [W-1:0] cnt_val,
  output logic         ovf,
  output logic         ch_out
);

  logic [W-1:0] per_q;
  logic [W-1:0] div_pend;
  logic [W-1:0] div_act;
  logic [W-1:0] psc;
  logic         run;
  logic         tick;
  logic         wrap;

  assign run  = (per_q != '0);
  assign tick = run && (psc == div_act);
  assign wrap = tick && (cnt_val == per_q) && !cnt_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q    <= '0;
      div_pend <= '0;
    end else begin
      if (per_we) per_q    <= per_wdata;
      if (div_we) div_pend <= div_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    psc <= '0;
    else if (run)  psc <= tick ? '0 : psc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     div_act <= '0;
    else if (wrap)  div_act <= div_pend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_val <= '0;
    else if (cnt_we)  cnt_val <= cnt_wdata;
    else if (tick)    cnt_val <= (cnt_val == per_q) ? '0 : cnt_val + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf <= 1'b0;
    else        ovf <= wrap;
  end

  assign ch_out = out_en & ~out_pol;

  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ovf |-> (cnt_val == '0)); // R3
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> !ovf); // R3
  AST_DIV_ONLY_AT_OVF: assert property (@(posedge clk) disable iff (!rst_n) !$stable(div_act) |-> ovf); // R4
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (per_q == '0 && !cnt_we) |=> $stable(cnt_val)); // R5
  AST_HALT_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n) (per_q == '0) |=> !ovf); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n) cnt_we |=> (cnt_val == $past(cnt_wdata))); // R6

endmodule

// File: tb/tmr_base_bench.sv
`timescale 1ns/1ps
module tmr_base_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_we = 1'b0, div_we = 1'b0, per_we = 1'b0;
  logic [15:0] cnt_wdata = '0, div_wdata = '0, per_wdata = '0;
  logic        out_en = 1'b0, out_pol = 1'b0;
  logic [15:0] cnt_val;
  logic        ovf, ch_out;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  tmr_base u_tmr_base (
    .clk(clk), .rst_n(rst_n),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .div_we(div_we), .div_wdata(div_wdata),
    .per_we(per_we), .per_wdata(per_wdata),
    .out_en(out_en), .out_pol(out_pol),
    .cnt_val(cnt_val), .ovf(ovf), .ch_out(ch_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cnt(input int v);
    cnt_we = 1'b1; cnt_wdata = 16'(v);
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic wr_div(input int v);
    div_we = 1'b1; div_wdata = 16'(v);
    @(negedge clk);
    div_we = 1'b0;
  endtask

  task automatic wr_per(input int v);
    per_we = 1'b1; per_wdata = 16'(v);
    @(negedge clk);
    per_we = 1'b0;
  endtask

  task automatic wait_ovf();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (ovf) return;
    end
    chk("R3 overflow seen", 0, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int c;
    int len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 counter reset", cnt_val, 0);
    chk("R1 ovf reset", ovf, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1 halted after reset", cnt_val, 0);
      chk("R5 no ovf while halted", ovf, 0);
    end

    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 2; p++) begin
        out_en = e[0]; out_pol = p[0];
        #1;
        chk("R7 channel output", ch_out, (e == 1 && p == 0) ? 1 : 0);
      end
    out_en = 1'b0; out_pol = 1'b0;

    @(negedge clk);
    wr_cnt(16'h1234);
    chk("R6 write while halted", cnt_val, 16'h1234);
    repeat (4) @(negedge clk);
    chk("R5 halted holds written value", cnt_val, 16'h1234);

    for (int d = 0; d < 4; d++)
      for (int p = 1; p < 5; p++) begin
        wr_div(d);
        wr_per(p);
        wr_cnt(0);
        wait_ovf();
        chk("R3 counter 0 at ovf", cnt_val, 0);
        len = (p + 1) * (d + 1);
        for (int k = 1; k <= len; k++) begin
          @(negedge clk);
          chk("R2 counter step", cnt_val, (k == len) ? 0 : k / (d + 1));
          chk("R3 ovf timing", ovf, (k == len) ? 1 : 0);
        end
      end

    // Active divider is now 3, period 4, and we are at an overflow cycle.
    wr_div(0);
    chk("R4 old divider still used", cnt_val, 0);
    for (int k = 2; k <= 20; k++) begin
      @(negedge clk);
      chk("R4 old ratio until ovf", cnt_val, (k == 20) ? 0 : k / 4);
      chk("R4 ovf with old ratio", ovf, (k == 20) ? 1 : 0);
    end
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk("R4 new ratio after ovf", cnt_val, k % 5);
      chk("R3 ovf with new ratio", ovf, (k == 5) ? 1 : 0);
    end

    wr_per(200);
    c = cnt_val;
    wr_cnt(100);
    chk("R6 write beats tick", cnt_val, 100);
    @(negedge clk);
    chk("R2 count resumes after write", cnt_val, 101);

    wr_per(0);
    c = cnt_val;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R5 halt holds counter", cnt_val, c);
      chk("R5 halt no ovf", ovf, 0);
    end
    wr_cnt(7);
    chk("R6 write during halt", cnt_val, 7);
    wr_per(8);
    chk("R8 no tick on period-write edge", cnt_val, 7);
    @(negedge clk);
    chk("R8 counts to new period", cnt_val, 8);
    @(negedge clk);
    chk("R8 wraps at new period", cnt_val, 0);
    chk("R3 ovf at new period", ovf, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule